// File: doc/BRIEF.md
# AES Key Store Controller

This block keeps AES key material in eight 128-bit storage areas and loads it from a stream of 32-bit words that stands in for a DMA channel. A host programs it through a small word-addressed register port. It claims the engine with a select register and picks a key size. It names the target areas in a write mask, frees any occupied areas in the written-status register, and then writes a byte count. The byte-count write starts the load. The block steers each incoming word into the correct area and word slot. When the load is complete it marks the areas as written and raises result-available and input-done flags.

A badly formed load (an empty mask, unaligned pairs for long keys, or a byte count that does not match the mask) raises a write-error flag instead. The areas stay unmarked and the stream is not consumed. A cipher core fetches keys through a separate read port by area index. Larger keys occupy an aligned pair of areas. A 192-bit key is held as 256 bits with its top 64 bits forced to zero. The status flags feed an interrupt that works either as a level or as a single-cycle pulse.

Top module: `key_vault`

## Requirements
- R1: After reset the select, write-mask, written-status, interrupt-status and interrupt-config registers read 0, the key-size register reads 1 (128-bit), `irq` is 0 and `kr_valid` is 0.
- R2: A write to the byte-count register (address 4) starts a load only while the select register (address 0, bit 0) reads 1 and no load is running; otherwise it changes no status and no stored key.
- R3: Key-size codes in address 1 bits [1:0] are 1 = 128, 2 = 192 and 3 = 256 bits. A write of a different nonzero code, made while no load runs, zeroes every stored key and clears all written-status bits. A write of the same code, or of code 0, keeps everything.
- R4: For 128-bit keys the areas set in the write mask (address 2) fill from the lowest set bit upward, 4 words each. Word w of an area lands in bits [32w+31:32w].
- R5: For 192-bit keys each key takes an aligned area pair, 8 stream words. The odd (upper) area's words 2 and 3 are stored as zero.
- R6: For 256-bit keys each key takes an aligned area pair, and all 8 stream words are stored unchanged.
- R7: When the last word of a valid load is taken, status bits 0 (result available) and 1 (input done) in address 5 set, and the masked areas become set in the written-status register (address 3). Each status bit stays set until 1 is written to the same bit of the clear register (address 6).
- R8: A load request whose mask is zero, whose mask is not made of aligned pairs while the key size is 192 or 256, or whose byte count is not 16 times the number of masked areas sets status bits 2 (write error) and 0 instead of starting. The written status is unchanged and following stream words are ignored.
- R9: Writing 1 to a bit of the written-status register clears that bit. Writing 0 leaves it unchanged.
- R10: Address 7 holds the interrupt enables in bits [2:0] and the mode in bit 8. With the mode at 1, `irq` equals the OR of status AND enable. With the mode at 0, `irq` pulses for exactly one cycle when that OR rises.
- R11: One cycle after `kr_req`, `kr_data` holds the key at `kr_area`, and `kr_valid` is 1 only if the area is written. For 128-bit keys the data is that area in the low half, with the high half zero. For longer keys the data is the aligned pair with the odd area in the high half, and both areas must be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| kin_valid | input | 1 | Key stream word present |
| kin_data | input | 32 | Key stream word |
| kr_req | input | 1 | Key read request |
| kr_area | input | 3 | Key read area index |
| kr_data | output | 256 | Key read data |
| kr_valid | output | 1 | Key read data is a written key |
| irq | output | 1 | Interrupt output |

## Verification
Directed loads use sparse 128-bit masks such as areas 2 and 5. These separate the lowest-bit-first fill order from a plain index mapping. Pair loads of 192 and 256 bits separate the zeroing of the upper half from a full store. Malformed requests cover an empty mask, a misaligned pair and a wrong byte count, and each has to fail without marking areas or consuming words. Seeded random loads mix key sizes, masks, byte counts and idle gaps in the stream, and every area is read back after each load. This shows that size changes erase exactly when the code differs and that earlier keys survive later loads.

// File: rtl/kv_pkg.sv
package kv_pkg;
    localparam logic [2:0] A_SEL    = 3'd0;
    localparam logic [2:0] A_KSIZE  = 3'd1;
    localparam logic [2:0] A_WAREA  = 3'd2;
    localparam logic [2:0] A_WRIT   = 3'd3;
    localparam logic [2:0] A_LEN    = 3'd4;
    localparam logic [2:0] A_STAT   = 3'd5;
    localparam logic [2:0] A_CLR    = 3'd6;
    localparam logic [2:0] A_ICFG   = 3'd7;

    localparam int ST_RES  = 0;
    localparam int ST_DONE = 1;
    localparam int ST_ERR  = 2;
    localparam int ST_W    = 3;

    typedef enum logic [1:0] {
        KS_NONE = 2'd0,
        KS_128  = 2'd1,
        KS_192  = 2'd2,
        KS_256  = 2'd3
    } ksize_e;

    function automatic int unsigned first_set(input logic [31:0] m);
        int unsigned r;
        r = 0;
        for (int i = 31; i >= 0; i--) begin
            if (m[i]) r = i;
        end
        return r;
    endfunction

    function automatic int unsigned ones(input logic [31:0] m);
        int unsigned r;
        r = 0;
        for (int i = 0; i < 32; i++) begin
            r += m[i];
        end
        return r;
    endfunction
endpackage

// File: rtl/kv_ctrl.sv
module kv_ctrl
    import kv_pkg::*;
#(
    parameter int N_AREAS = 8,
    parameter int AREA_W  = 128,
    parameter int WORD_W  = 32,
    parameter int LEN_W   = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [2:0]                 reg_addr,
    input  logic [31:0]                reg_wdata,
    output logic [31:0]                reg_rdata,
    input  logic                       kin_valid,
    input  logic [WORD_W-1:0]          kin_data,
    output logic                       st_wr_en,
    output logic [$clog2(N_AREAS)-1:0] st_wr_area,
    output logic [$clog2(AREA_W/WORD_W)-1:0] st_wr_word,
    output logic [WORD_W-1:0]          st_wr_data,
    output logic                       st_erase,
    output ksize_e                     ksize,
    output logic [N_AREAS-1:0]         written,
    output logic [ST_W-1:0]            stat,
    output logic [ST_W-1:0]            ien,
    output logic                       level
);
    localparam int AIDX_W = $clog2(N_AREAS);
    localparam int WPA    = AREA_W / WORD_W;
    localparam int WIDX_W = $clog2(WPA);
    localparam int BPA    = AREA_W / 8;

    typedef struct packed {
        logic               sel;
        ksize_e             ksize;
        logic [N_AREAS-1:0] warea;
        logic [N_AREAS-1:0] written;
        logic [N_AREAS-1:0] load_mask;
        logic [N_AREAS-1:0] remain;
        logic [ST_W-1:0]    stat;
        logic [ST_W-1:0]    ien;
        logic               level;
        logic               loading;
        logic [WIDX_W-1:0]  widx;
    } ctrl_t;

    ctrl_t s_q, s_d;

    logic [AIDX_W-1:0] cur_area;
    logic              req_ok;
    logic              pairs_ok;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[31:9];

    always_comb begin
        pairs_ok = 1'b1;
        for (int i = 0; i < N_AREAS / 2; i++) begin
            if (s_q.warea[2*i] != s_q.warea[2*i+1]) pairs_ok = 1'b0;
        end
        req_ok = (s_q.warea != '0)
              && (s_q.ksize == KS_128 || pairs_ok)
              && (reg_wdata[LEN_W-1:0] == LEN_W'(ones(32'(s_q.warea)) * BPA));
        cur_area = AIDX_W'(first_set(32'(s_q.remain)));
    end

    always_comb begin
        s_d        = s_q;
        st_erase   = 1'b0;
        st_wr_en   = s_q.loading & kin_valid;
        st_wr_area = cur_area;
        st_wr_word = s_q.widx;
        st_wr_data = kin_data;
        if (s_q.ksize == KS_192 && cur_area[0] && (int'(s_q.widx) >= WPA / 2))
            st_wr_data = '0;

        if (reg_we) begin
            unique case (reg_addr)
                A_SEL:   s_d.sel = reg_wdata[0];
                A_KSIZE: begin
                    if (!s_q.loading && reg_wdata[1:0] != 2'd0
                        && ksize_e'(reg_wdata[1:0]) != s_q.ksize) begin
                        s_d.ksize   = ksize_e'(reg_wdata[1:0]);
                        s_d.written = '0;
                        st_erase    = 1'b1;
                    end
                end
                A_WAREA: s_d.warea = reg_wdata[N_AREAS-1:0];
                A_WRIT:  s_d.written = s_q.written & ~reg_wdata[N_AREAS-1:0];
                A_LEN: begin
                    if (s_q.sel && !s_q.loading) begin
                        if (req_ok) begin
                            s_d.loading   = 1'b1;
                            s_d.remain    = s_q.warea;
                            s_d.load_mask = s_q.warea;
                            s_d.widx      = '0;
                        end else begin
                            s_d.stat[ST_ERR] = 1'b1;
                            s_d.stat[ST_RES] = 1'b1;
                        end
                    end
                end
                A_CLR:   s_d.stat = s_q.stat & ~reg_wdata[ST_W-1:0];
                A_ICFG: begin
                    s_d.ien   = reg_wdata[ST_W-1:0];
                    s_d.level = reg_wdata[8];
                end
                default: ;
            endcase
        end

        if (st_wr_en) begin
            s_d.widx = s_q.widx + 1'b1;
            if (s_q.widx == WIDX_W'(WPA - 1)) begin
                s_d.remain = s_q.remain & ~(N_AREAS'(1) << cur_area);
                if (s_d.remain == '0) begin
                    s_d.loading       = 1'b0;
                    s_d.stat[ST_RES]  = 1'b1;
                    s_d.stat[ST_DONE] = 1'b1;
                    s_d.written       = s_d.written | s_q.load_mask;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.ksize <= KS_128;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_SEL:   reg_rdata = 32'(s_q.sel);
            A_KSIZE: reg_rdata = 32'(s_q.ksize);
            A_WAREA: reg_rdata = 32'(s_q.warea);
            A_WRIT:  reg_rdata = 32'(s_q.written);
            A_STAT:  reg_rdata = 32'(s_q.stat);
            A_ICFG:  reg_rdata = {23'd0, s_q.level, 5'd0, s_q.ien};
            default: reg_rdata = '0;
        endcase
    end

    assign ksize   = s_q.ksize;
    assign written = s_q.written;
    assign stat    = s_q.stat;
    assign ien     = s_q.ien;
    assign level   = s_q.level;

    assert_done_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.stat[ST_DONE]) |-> ((s_q.written & s_q.load_mask) == s_q.load_mask));

    assert_err_keeps_written_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.stat[ST_ERR]) |-> $stable(s_q.written));

    assert_len_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_LEN && !s_q.sel && !s_q.loading)
        |=> (!s_q.loading && $stable(s_q.stat)));
endmodule

// File: rtl/kv_store.sv
module kv_store
    import kv_pkg::*;
#(
    parameter int N_AREAS = 8,
    parameter int AREA_W  = 128,
    parameter int WORD_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(N_AREAS)-1:0] wr_area,
    input  logic [$clog2(AREA_W/WORD_W)-1:0] wr_word,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic                       erase,
    input  ksize_e                     ksize,
    input  logic [N_AREAS-1:0]         written,
    input  logic                       kr_req,
    input  logic [$clog2(N_AREAS)-1:0] kr_area,
    output logic [2*AREA_W-1:0]        kr_data,
    output logic                       kr_valid
);
    localparam int AIDX_W = $clog2(N_AREAS);

    typedef struct packed {
        logic [N_AREAS-1:0][AREA_W-1:0] mem;
        logic [2*AREA_W-1:0]            rdata;
        logic                           rvalid;
    } store_t;

    store_t s_q, s_d;
    logic [AIDX_W-1:0] base, upper;
    logic              any_nz;

    always_comb begin
        s_d    = s_q;
        base   = {kr_area[AIDX_W-1:1], 1'b0};
        upper  = {kr_area[AIDX_W-1:1], 1'b1};
        if (erase) begin
            s_d.mem = '0;
        end else if (wr_en) begin
            s_d.mem[wr_area][wr_word*WORD_W +: WORD_W] = wr_data;
        end
        s_d.rvalid = 1'b0;
        if (kr_req) begin
            if (ksize == KS_128) begin
                s_d.rdata  = {{AREA_W{1'b0}}, s_q.mem[kr_area]};
                s_d.rvalid = written[kr_area];
            end else begin
                s_d.rdata  = {s_q.mem[upper], s_q.mem[base]};
                s_d.rvalid = written[base] & written[upper];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign kr_data  = s_q.rdata;
    assign kr_valid = s_q.rvalid;

    always_comb begin
        any_nz = 1'b0;
        for (int i = 0; i < N_AREAS; i++) any_nz |= (|s_q.mem[i]);
    end

    assert_erase_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> !any_nz);

    assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        kr_valid |-> $past(kr_req));
endmodule

// File: rtl/kv_irq.sv
module kv_irq
    import kv_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] stat,
    input  logic [ST_W-1:0] ien,
    input  logic            level,
    output logic            irq
);
    typedef struct packed {
        logic prev;
    } irq_t;

    irq_t s_q, s_d;
    logic any;

    always_comb begin
        any      = |(stat & ien);
        s_d.prev = any;
        irq      = level ? any : (any & ~s_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!level && irq) |=> (!irq || level));
endmodule

// File: rtl/key_vault.sv
module key_vault
    import kv_pkg::*;
#(
    parameter int N_AREAS = 8,
    parameter int AREA_W  = 128,
    parameter int WORD_W  = 32,
    parameter int LEN_W   = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [2:0]                 reg_addr,
    input  logic [31:0]                reg_wdata,
    output logic [31:0]                reg_rdata,
    input  logic                       kin_valid,
    input  logic [WORD_W-1:0]          kin_data,
    input  logic                       kr_req,
    input  logic [$clog2(N_AREAS)-1:0] kr_area,
    output logic [2*AREA_W-1:0]        kr_data,
    output logic                       kr_valid,
    output logic                       irq
);
    localparam int AIDX_W = $clog2(N_AREAS);
    localparam int WIDX_W = $clog2(AREA_W / WORD_W);

    logic               wr_en, erase, level;
    logic [AIDX_W-1:0]  wr_area;
    logic [WIDX_W-1:0]  wr_word;
    logic [WORD_W-1:0]  wr_data;
    ksize_e             ksize;
    logic [N_AREAS-1:0] written;
    logic [ST_W-1:0]    stat, ien;

    kv_ctrl #(.N_AREAS(N_AREAS), .AREA_W(AREA_W), .WORD_W(WORD_W), .LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .kin_valid(kin_valid), .kin_data(kin_data),
        .st_wr_en(wr_en), .st_wr_area(wr_area), .st_wr_word(wr_word), .st_wr_data(wr_data),
        .st_erase(erase), .ksize(ksize), .written(written),
        .stat(stat), .ien(ien), .level(level)
    );

    kv_store #(.N_AREAS(N_AREAS), .AREA_W(AREA_W), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_area(wr_area), .wr_word(wr_word), .wr_data(wr_data),
        .erase(erase), .ksize(ksize), .written(written),
        .kr_req(kr_req), .kr_area(kr_area), .kr_data(kr_data), .kr_valid(kr_valid)
    );

    kv_irq u_irq (
        .clk(clk), .rst_n(rst_n), .stat(stat), .ien(ien), .level(level), .irq(irq)
    );
endmodule

// File: tb/sim_key_vault.sv
module sim_key_vault;
    timeunit 1ns;
    timeprecision 1ps;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         kin_valid = 1'b0;
    logic [31:0]  kin_data = '0;
    logic         kr_req = 1'b0;
    logic [2:0]   kr_area = '0;
    logic [255:0] kr_data;
    logic         kr_valid;
    logic         irq;

    int n_tests = 0;
    int n_fail  = 0;
    int irq_cnt = 0;

    logic [127:0] m_mem [8];
    logic [7:0]   m_wr;
    int           m_ks;

    always #2 clk = ~clk;
    always @(negedge clk) if (irq) irq_cnt++;

    key_vault u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .kin_valid(kin_valid),
        .kin_data(kin_data), .kr_req(kr_req), .kr_area(kr_area),
        .kr_data(kr_data), .kr_valid(kr_valid), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic keyread(input logic [2:0] a, output logic [255:0] d, output logic v);
        @(negedge clk);
        kr_req = 1'b1; kr_area = a;
        @(negedge clk);
        kr_req = 1'b0;
        d = kr_data; v = kr_valid;
    endtask

    function automatic bit mask_ok(input int ks, input logic [7:0] m, input int len);
        bit pairs;
        pairs = 1'b1;
        for (int i = 0; i < 4; i++) if (m[2*i] != m[2*i+1]) pairs = 1'b0;
        return (m != 0) && (ks == 1 || pairs) && (len == 16 * $countones(m));
    endfunction

    task automatic set_ks(input int ks);
        wr(3'd1, ks);
        if (ks != 0 && ks != m_ks) begin
            m_ks = ks;
            m_wr = '0;
            for (int i = 0; i < 8; i++) m_mem[i] = '0;
        end
    endtask

    task automatic check_all(input string req);
        logic [255:0] d, e;
        logic         v, ev;
        for (int a = 0; a < 8; a++) begin
            if (m_ks == 1) begin
                e = {128'd0, m_mem[a]}; ev = m_wr[a];
            end else begin
                e  = {m_mem[a | 1], m_mem[a & 6]};
                ev = m_wr[a | 1] & m_wr[a & 6];
            end
            keyread(a[2:0], d, v);
            chk(d == e, req, $sformatf("key data area %0d", a), d, e);
            chk(v == ev, req, $sformatf("key valid area %0d", a), 256'(v), 256'(ev));
        end
    endtask

    task automatic do_load(input int ks, input logic [7:0] mask, input int len,
                           input bit keep_stat, input string req);
        bit ok;
        int nw, k;
        logic [31:0] words [64];
        logic [31:0] r;
        wr(3'd0, 1);
        set_ks(ks);
        wr(3'd3, 32'(mask)); m_wr &= ~mask;
        wr(3'd2, 32'(mask));
        wr(3'd6, 7);
        wr(3'd4, len);
        ok = mask_ok(m_ks, mask, len);
        nw = ok ? 4 * $countones(mask) : 4;
        for (int i = 0; i < nw; i++) begin
            words[i] = $urandom;
            if ($urandom % 4 == 0) begin kin_valid = 1'b0; @(negedge clk); end
            kin_valid = 1'b1; kin_data = words[i];
            @(negedge clk);
        end
        kin_valid = 1'b0;
        if (ok) begin
            k = 0;
            for (int a = 0; a < 8; a++) begin
                if (mask[a]) begin
                    for (int w = 0; w < 4; w++) begin
                        m_mem[a][32*w +: 32] = (m_ks == 2 && a[0] && w >= 2) ? 32'd0 : words[k];
                        k++;
                    end
                end
            end
            m_wr |= mask;
        end
        rd(3'd5, r);
        chk(r == (ok ? 32'd3 : 32'd5), ok ? "R7" : "R8", "status after load",
            256'(r), 256'(ok ? 3 : 5));
        rd(3'd3, r);
        chk(r == 32'(m_wr), ok ? "R7" : "R8", "written after load", 256'(r), 256'(m_wr));
        if (!keep_stat) begin
            wr(3'd6, 7);
            rd(3'd5, r);
            chk(r == 0, "R7", "status after clear", 256'(r), 256'd0);
        end
        wr(3'd0, 0);
        check_all(req);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0]  r;
        logic [255:0] d;
        logic         v;
        logic [7:0]   m;
        int           ks, len;
        void'($urandom(32'd1234));
        m_ks = 1; m_wr = '0;
        for (int i = 0; i < 8; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(3'd0, r); chk(r == 0, "R1", "select", 256'(r), 0);
        rd(3'd1, r); chk(r == 1, "R1", "key size", 256'(r), 1);
        rd(3'd3, r); chk(r == 0, "R1", "written", 256'(r), 0);
        rd(3'd5, r); chk(r == 0, "R1", "status", 256'(r), 0);
        rd(3'd7, r); chk(r == 0, "R1", "icfg", 256'(r), 0);
        chk(irq == 0, "R1", "irq", 256'(irq), 0);
        chk(kr_valid == 0, "R1", "kr_valid", 256'(kr_valid), 0);

        // R2 length write without select is ignored
        wr(3'd2, 32'h03);
        wr(3'd4, 32);
        kin_valid = 1'b1; kin_data = 32'hDEAD_BEEF;
        repeat (4) @(negedge clk);
        kin_valid = 1'b0;
        rd(3'd5, r); chk(r == 0, "R2", "status after ungated len", 256'(r), 0);
        rd(3'd3, r); chk(r == 0, "R2", "written after ungated len", 256'(r), 0);
        check_all("R2");

        // R4 sparse 128-bit fill order
        do_load(1, 8'b0010_0100, 32, 1'b0, "R4");

        // R9 written-status clear semantics
        wr(3'd3, 0);
        rd(3'd3, r); chk(r == 32'h24, "R9", "write 0 keeps", 256'(r), 256'h24);
        wr(3'd3, 32'h04); m_wr &= ~8'h04;
        rd(3'd3, r); chk(r == 32'h20, "R9", "write 1 frees", 256'(r), 256'h20);
        keyread(3'd2, d, v); chk(v == 0, "R9", "freed area invalid", 256'(v), 0);

        // R3 same code keeps, code 0 ignored, new code erases
        wr(3'd1, 1);
        rd(3'd3, r); chk(r == 32'h20, "R3", "same size keeps", 256'(r), 256'h20);
        wr(3'd1, 0);
        rd(3'd1, r); chk(r == 1, "R3", "code 0 ignored", 256'(r), 1);
        set_ks(3);
        rd(3'd3, r); chk(r == 0, "R3", "size change clears written", 256'(r), 0);
        check_all("R3");

        // R6 256-bit pair, R5 192-bit pair
        do_load(3, 8'b0011_0000, 32, 1'b0, "R6");
        do_load(2, 8'b0000_1111, 64, 1'b0, "R5");

        // R8 malformed requests
        do_load(2, 8'b0000_0110, 32, 1'b0, "R8");
        do_load(2, 8'b0000_0000, 0, 1'b0, "R8");
        do_load(1, 8'b0000_0001, 48, 1'b0, "R8");

        // R10 level mode
        wr(3'd7, 32'h101);
        do_load(1, 8'b1000_0000, 16, 1'b1, "R10");
        chk(irq == 1, "R10", "level irq held", 256'(irq), 1);
        wr(3'd6, 1);
        @(negedge clk);
        chk(irq == 0, "R10", "level irq after clear", 256'(irq), 0);
        wr(3'd6, 7);
        // R10 pulse mode
        wr(3'd7, 32'h002);
        irq_cnt = 0;
        do_load(1, 8'b0100_0000, 16, 1'b1, "R10");
        repeat (5) @(negedge clk);
        chk(irq_cnt == 1, "R10", "pulse width cycles", 256'(irq_cnt), 1);
        wr(3'd6, 7);
        wr(3'd7, 0);

        // R11 random loads with full readback
        for (int it = 0; it < 30; it++) begin
            ks = 1 + ($urandom % 3);
            m  = $urandom;
            if ($urandom % 3 != 0 && ks != 1) m = m | {m[6], m[7], m[4], m[5], m[2], m[3], m[0], m[1]};
            len = ($urandom % 5 == 0) ? 16 * ($urandom % 9) : 16 * $countones(m);
            do_load(ks, m, len, 1'b0, "R11");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule